// File: doc/BRIEF.md
# Stackless Pipelined Microprogram Sequencer

This block forms the control-store address for a microprogrammed engine whose control store has a synchronous read. The address register `seq_addr` is the address being fetched. The microword it returns is the one that executes in the next cycle. The microword executing now therefore drives the branch fields, while its successor is already on its way. Each control transfer carries an annul bit. The bit chooses whether that successor, the delay-slot word, runs or is turned into a no-op. The block reports that choice on `slot_kill`.

The sequencer keeps no return-address stack. A subroutine call is a plain jump, and the caller has stored its return address in an ordinary register beforehand. The return is a jump to an address taken from the result bus, and the same branch kind serves for computed case dispatch. Instruction dispatch uses a mapping memory. It is indexed by the opcode bits of the memory data register, so dispatch can happen before the instruction register is loaded. Interrupts are never taken on their own: a dedicated branch kind jumps only while an interrupt is pending. The mapping memory is loaded through a simple write port.

Top module: `mseq_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `seq_addr` is 0 and `slot_kill` is 1.
- R2: A live microword of kind SEQ (code 0) makes the next `seq_addr` equal to the current one plus 1, wrapping from 8191 to 0.
- R3: Kind JMP (code 1) loads `seq_addr` with bits [12:0] of `tgt_a`. Bits [15:13] of the target fields are ignored.
- R4: Kind COND2 (code 2) loads bits [12:0] of `tgt_a` when `cond_flags[cond_sel]` is 1, and bits [12:0] of `tgt_b` when it is 0.
- R5: Kind CONDJ (code 3) loads bits [12:0] of `tgt_a` when `cond_flags[cond_sel]` is 1, and otherwise steps by 1.
- R6: Kind RBUS (code 4) loads `seq_addr` with bits [12:0] of `rbus`.
- R7: Kind MAP (code 5) loads `seq_addr` with the mapping entry indexed by `mdr[31:22]`. Asserting `map_we` writes `map_wdata` into entry `map_waddr` at the clock edge.
- R8: Kind IRQ (code 6) loads bits [12:0] of `tgt_a` when `irq_pend` is 1, and otherwise steps by 1.
- R9: `slot_kill` is 1 in the cycle after a live transfer that redirects with `br_annul` set. A transfer counts as redirecting when it is JMP, COND2, RBUS or MAP, when it is CONDJ with its flag true, or when it is IRQ with an interrupt pending. In every other case after a live microword, `slot_kill` is 0.
- R10: While `slot_kill` is 1, all branch inputs are ignored: the next `seq_addr` is the current one plus 1, and `slot_kill` returns to 0.
- R11: Kind code 7 is reserved and behaves as SEQ. It never annuls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_kind | input | 3 | Branch kind of the executing microword |
| br_annul | input | 1 | Annul the delay slot when this transfer redirects |
| cond_sel | input | 2 | Selects one of the condition flags |
| cond_flags | input | 4 | Condition flags |
| tgt_a | input | 16 | First target field |
| tgt_b | input | 16 | Second target field |
| rbus | input | 32 | Result bus |
| mdr | input | 32 | Memory data register; bits [31:22] index the mapping memory |
| irq_pend | input | 1 | Interrupt pending |
| map_we | input | 1 | Mapping memory write enable |
| map_waddr | input | 10 | Mapping memory write index |
| map_wdata | input | 13 | Mapping memory write data |
| seq_addr | output | 13 | Control-store fetch address |
| slot_kill | output | 1 | The microword executing in this cycle is annulled |

## Verification
Every result of this block lands exactly one clock after the microword that causes it. The new fetch address, the kill flag for the delay slot and a write to the mapping memory are all due at the next rising edge. The bench drives a microword's fields at a falling edge. It computes the expected address and kill flag from its own model of the requirements, then compares both outputs at the following falling edge, half a period after the edge that produced them. A write to the mapping memory only affects a dispatch in a later cycle, and the model applies its copy of each write after that cycle's prediction, so the two stay in step.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
   typedef enum logic [2:0] {
      BK_SEQ   = 3'd0,
      BK_JMP   = 3'd1,
      BK_COND2 = 3'd2,
      BK_CONDJ = 3'd3,
      BK_RBUS  = 3'd4,
      BK_MAP   = 3'd5,
      BK_IRQ   = 3'd6,
      BK_RSVD  = 3'd7
   } br_kind_e;
endpackage

// File: rtl/mseq_map_ram.sv
module mseq_map_ram #(
   parameter int IDX_W  = 10,
   parameter int WORD_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [WORD_W-1:0] rdata
);
   localparam int DEPTH = 1 << IDX_W;

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

   // R7: a write lands in the addressed entry at the edge
   p_map_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/mseq_cond_mux.sv
module mseq_cond_mux #(
   parameter int NUM_COND = 4,
   parameter int SEL_W    = (NUM_COND > 1) ? $clog2(NUM_COND) : 1
) (
   input  logic [NUM_COND-1:0] flags,
   input  logic [SEL_W-1:0]    sel,
   output logic                cond
);
   generate
      if (NUM_COND == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^sel;
         assign cond = flags[0];
      end else begin : g_multi
         assign cond = flags[sel];
      end
   endgenerate
endmodule

// File: rtl/mseq_next_sel.sv
module mseq_next_sel
   import mseq_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int TGT_W  = 16,
   parameter int DATA_W = 32
) (
   input  br_kind_e            kind,
   input  logic                annul,
   input  logic                killed,
   input  logic                cond,
   input  logic                irq,
   input  logic [ADDR_W-1:0]   cur,
   input  logic [TGT_W-1:0]    ta,
   input  logic [TGT_W-1:0]    tb,
   input  logic [DATA_W-1:0]   rb,
   input  logic [ADDR_W-1:0]   mapped,
   output logic [ADDR_W-1:0]   nxt,
   output logic                kill_nxt
);
   logic [ADDR_W-1:0] step, ta_a, tb_a, rb_a;
   logic              redirect;
   logic              unused_hi;

   assign step = cur + ADDR_W'(1);
   assign ta_a = ta[ADDR_W-1:0];
   assign tb_a = tb[ADDR_W-1:0];
   assign rb_a = rb[ADDR_W-1:0];
   assign unused_hi = ^{ta[TGT_W-1:ADDR_W], tb[TGT_W-1:ADDR_W], rb[DATA_W-1:ADDR_W]};

   always_comb begin
      nxt      = step;
      redirect = 1'b0;
      if (!killed) begin
         unique case (kind)
            BK_JMP:   begin nxt = ta_a; redirect = 1'b1; end
            BK_COND2: begin nxt = cond ? ta_a : tb_a; redirect = 1'b1; end
            BK_CONDJ: begin if (cond) begin nxt = ta_a; redirect = 1'b1; end end
            BK_RBUS:  begin nxt = rb_a; redirect = 1'b1; end
            BK_MAP:   begin nxt = mapped; redirect = 1'b1; end
            BK_IRQ:   begin if (irq) begin nxt = ta_a; redirect = 1'b1; end end
            default:  begin nxt = step; redirect = 1'b0; end
         endcase
      end
      kill_nxt = redirect & annul;
   end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
   import mseq_pkg::*;
#(
   parameter int ADDR_W   = 13,
   parameter int TGT_W    = 16,
   parameter int DATA_W   = 32,
   parameter int OPC_W    = 10,
   parameter int NUM_COND = 4,
   parameter int SEL_W    = (NUM_COND > 1) ? $clog2(NUM_COND) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          br_kind,
   input  logic                br_annul,
   input  logic [SEL_W-1:0]    cond_sel,
   input  logic [NUM_COND-1:0] cond_flags,
   input  logic [TGT_W-1:0]    tgt_a,
   input  logic [TGT_W-1:0]    tgt_b,
   input  logic [DATA_W-1:0]   rbus,
   input  logic [DATA_W-1:0]   mdr,
   input  logic                irq_pend,
   input  logic                map_we,
   input  logic [OPC_W-1:0]    map_waddr,
   input  logic [ADDR_W-1:0]   map_wdata,
   output logic [ADDR_W-1:0]   seq_addr,
   output logic                slot_kill
);
   localparam int OPC_LSB = DATA_W - OPC_W;

   generate
      if (TGT_W < ADDR_W)   begin : g_bad_tgt  $error("target field narrower than address"); end
      if (DATA_W < ADDR_W)  begin : g_bad_data $error("result bus narrower than address"); end
      if (OPC_W > DATA_W)   begin : g_bad_opc  $error("opcode field wider than data word"); end
      if (NUM_COND < 1)     begin : g_bad_cond $error("need at least one condition flag"); end
   endgenerate

   br_kind_e          kind;
   logic              cond;
   logic [ADDR_W-1:0] mapped, nxt;
   logic              kill_nxt;

   assign kind = br_kind_e'(br_kind);

   mseq_cond_mux #(.NUM_COND(NUM_COND), .SEL_W(SEL_W)) i_cond (
      .flags(cond_flags), .sel(cond_sel), .cond(cond));

   mseq_map_ram #(.IDX_W(OPC_W), .WORD_W(ADDR_W)) i_map (
      .clk(clk), .rst_n(rst_n), .we(map_we), .waddr(map_waddr),
      .wdata(map_wdata), .raddr(mdr[DATA_W-1:OPC_LSB]), .rdata(mapped));

   mseq_next_sel #(.ADDR_W(ADDR_W), .TGT_W(TGT_W), .DATA_W(DATA_W)) i_sel (
      .kind(kind), .annul(br_annul), .killed(slot_kill), .cond(cond),
      .irq(irq_pend), .cur(seq_addr), .ta(tgt_a), .tb(tgt_b), .rb(rbus),
      .mapped(mapped), .nxt(nxt), .kill_nxt(kill_nxt));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq_addr  <= '0;
         slot_kill <= 1'b1;
      end else begin
         seq_addr  <= nxt;
         slot_kill <= kill_nxt;
      end
   end

   // R10: an annulled word never branches and never annuls its successor
   p_killed_steps_r10: assert property (@(posedge clk) disable iff (!rst_n)
      slot_kill |=> (!slot_kill && seq_addr == $past(seq_addr) + ADDR_W'(1)));
   // R2 / R11: sequential and reserved kinds step by one without annulling
   p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_kill && (kind == BK_SEQ || kind == BK_RSVD))
      |=> (!slot_kill && seq_addr == $past(seq_addr) + ADDR_W'(1)));
   // R3: unconditional jump reaches the low target bits
   p_jump_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_kill && kind == BK_JMP) |=> (seq_addr == $past(tgt_a[ADDR_W-1:0])));
   // R8: no interrupt pending means the interrupt test falls through
   p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_kill && kind == BK_IRQ && !irq_pend)
      |=> (!slot_kill && seq_addr == $past(seq_addr) + ADDR_W'(1)));
   // R9: without the annul bit the delay slot always runs
   p_no_annul_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_kill && !br_annul) |=> !slot_kill);
   // R6: result-bus jump
   p_rbus_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_kill && kind == BK_RBUS) |=> (seq_addr == $past(rbus[ADDR_W-1:0])));
endmodule

// File: tb/test_mseq_top.sv
module test_mseq_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  br_kind = 3'd0;
   logic        br_annul = 1'b0;
   logic [1:0]  cond_sel = 2'd0;
   logic [3:0]  cond_flags = 4'd0;
   logic [15:0] tgt_a = 16'd0, tgt_b = 16'd0;
   logic [31:0] rbus = 32'd0, mdr = 32'd0;
   logic        irq_pend = 1'b0;
   logic        map_we = 1'b0;
   logic [9:0]  map_waddr = 10'd0;
   logic [12:0] map_wdata = 13'd0;
   logic [12:0] seq_addr;
   logic        slot_kill;

   always #10 clk = ~clk;

   mseq_top i_mseq_top (
      .clk(clk), .rst_n(rst_n), .br_kind(br_kind), .br_annul(br_annul),
      .cond_sel(cond_sel), .cond_flags(cond_flags), .tgt_a(tgt_a), .tgt_b(tgt_b),
      .rbus(rbus), .mdr(mdr), .irq_pend(irq_pend), .map_we(map_we),
      .map_waddr(map_waddr), .map_wdata(map_wdata),
      .seq_addr(seq_addr), .slot_kill(slot_kill));

   int checks = 0;
   int errors = 0;
   int m_addr = 0;
   bit m_kill = 1'b1;
   int m_map [1024];
   bit m_map_ok [1024];
   string tag;
   int cycles = 0;

   always @(posedge clk) cycles <= cycles + 1;

   initial begin
      wait (cycles > 150000);
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Predict the next address and kill flag from the inputs now applied
   task automatic predict(output int na, output bit nk);
      int  step;
      bit  c;
      step = (m_addr + 1) % 8192;
      c    = cond_flags[cond_sel];
      na = step; nk = 1'b0;
      if (m_kill) begin
         tag = "R10";
      end else begin
         case (br_kind)
            3'd1: begin na = tgt_a % 8192; nk = br_annul; tag = "R3"; end
            3'd2: begin na = c ? tgt_a % 8192 : tgt_b % 8192; nk = br_annul; tag = "R4"; end
            3'd3: begin if (c) begin na = tgt_a % 8192; nk = br_annul; end tag = "R5"; end
            3'd4: begin na = rbus % 8192; nk = br_annul; tag = "R6"; end
            3'd5: begin na = m_map[mdr[31:22]]; nk = br_annul; tag = "R7"; end
            3'd6: begin if (irq_pend) begin na = tgt_a % 8192; nk = br_annul; end tag = "R8"; end
            3'd7: tag = "R11";
            default: tag = "R2";
         endcase
         if (nk) tag = {tag, "/R9"};
      end
      if (map_we) begin m_map[map_waddr] = map_wdata; m_map_ok[map_waddr] = 1'b1; end
   endtask

   // Inputs are already set after a falling edge; advance one cycle and compare
   task automatic step_check();
      int na; bit nk;
      predict(na, nk);
      @(negedge clk);
      m_addr = na; m_kill = nk;
      chk({tag, " addr"}, seq_addr, m_addr);
      chk({tag, " kill"}, slot_kill, m_kill);
   endtask

   task automatic drive(input int k, input bit an, input int ta, input int tb);
      br_kind = k[2:0]; br_annul = an; tgt_a = ta[15:0]; tgt_b = tb[15:0];
      map_we = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) begin m_map[i] = 0; m_map_ok[i] = 1'b0; end
      repeat (3) @(negedge clk);
      chk("R1 addr in reset", seq_addr, 0);
      chk("R1 kill in reset", slot_kill, 1);
      rst_n = 1'b1;
      // First cycle after reset: inputs ask for a jump, which must be ignored
      drive(1, 1, 16'h0123, 0);
      step_check();
      // Load the whole mapping memory while running sequentially
      for (int i = 0; i < 1024; i++) begin
         drive(0, 0, 0, 0);
         map_we = 1'b1; map_waddr = i[9:0]; map_wdata = 13'((i * 37 + 5) % 8192);
         step_check();
      end
      map_we = 1'b0;
      // Wrap at the top of the address range (R2)
      drive(1, 0, 16'hFFFF, 0); step_check();   // R3: upper bits dropped -> 8191
      drive(0, 0, 0, 0);        step_check();   // R2: 8191 -> 0
      // Reserved kind (R11), annul bit set but no effect
      drive(7, 1, 16'h0055, 0); step_check();
      // Annulled jump then a killed word carrying a jump (R9, R10)
      drive(1, 1, 16'h0200, 0); step_check();
      drive(1, 1, 16'h0777, 0); step_check();
      // Two-way condition, both outcomes (R4)
      cond_sel = 2'd2; cond_flags = 4'b0100;
      drive(2, 0, 16'h0300, 16'h0400); step_check();
      cond_flags = 4'b1011;
      drive(2, 0, 16'h0300, 16'h0400); step_check();
      // Conditional jump not taken with annul: no kill (R5, R9)
      drive(3, 1, 16'h0500, 0); step_check();
      cond_flags = 4'b0100;
      drive(3, 1, 16'h0500, 0); step_check();
      drive(0, 0, 0, 0); step_check();
      // Result-bus jump (R6)
      rbus = 32'hABCD_1234; drive(4, 0, 0, 0); step_check();
      // Mapped dispatch (R7)
      mdr = {10'd3, 22'h3F_FFFF}; drive(5, 0, 0, 0); step_check();
      mdr = {10'd1023, 22'd0};    drive(5, 1, 0, 0); step_check();
      drive(0, 0, 0, 0); step_check();
      // Interrupt test both ways (R8)
      irq_pend = 1'b0; drive(6, 1, 16'h0600, 0); step_check();
      irq_pend = 1'b1; drive(6, 0, 16'h0600, 0); step_check();
      // Random mix
      for (int n = 0; n < 4000; n++) begin
         drive($urandom % 8, $urandom % 2, $urandom, $urandom);
         cond_sel = 2'($urandom); cond_flags = 4'($urandom);
         rbus = $urandom; mdr = $urandom; irq_pend = 1'($urandom);
         if ($urandom % 8 == 0) begin
            map_we = 1'b1; map_waddr = 10'($urandom); map_wdata = 13'($urandom);
         end
         step_check();
      end
      // Reset again mid-run (R1)
      rst_n = 1'b0; drive(1, 0, 16'h0999, 0);
      @(negedge clk);
      chk("R1 addr after reset", seq_addr, 0);
      chk("R1 kill after reset", slot_kill, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule